// File: doc/BRIEF.md
# Messaging Unit Queue Ports

This block is the device-side register window through which a host and a local controller trade work. The host sees a small register map behind a simple 32-bit access port. Reading the inbound queue port hands out the offset of a free request packet in device memory. Writing the inbound queue port posts a request token. Writing the outbound queue port hands a device-memory packet back to the free pool. Reading the outbound queue port retrieves a completed token. The local controller has its own access port. Through it the controller drains posted tokens, pushes completions, reads inbound messages and the doorbell, and answers with outbound messages.

Tokens are opaque 32-bit words and travel through the queues unchanged. A request held in host memory is posted as bit 31 set, with the host byte address shifted right by five in the low bits. This works because such requests sit on 32-byte boundaries. A non-queued command goes into inbound message 0. The controller signals that the command is complete by writing the identical value into outbound message 0. The block detects this echo and flags it as an interrupt cause.

Each side has an interrupt output. The output is the OR of that side's status bits that are not masked.

Top module: `mu_top`

## Requirements
- R1: After a synchronous active-low reset, every status, mask, message and doorbell register reads 0, and `host_irq` and `loc_irq` are low.
- R2: At reset the free pool holds FREE_COUNT offsets, FREE_BASE + i*FREE_STEP (defaults 0x1000, 0x100, 4). Host reads of address 0x40 pop them in ascending i.
- R3: A read of an empty queue port returns 0xFFFFFFFF and changes no state. This holds for host 0x40, host 0x44 and local 0x00.
- R4: A host write to 0x40 posts its data unchanged, including tagged values of the form 0x80000000 | (addr >> 5). Local reads of 0x00 pop the posted tokens in arrival order.
- R5: A local write to 0x04 pushes a completion token. Host reads of 0x44 pop completions in order. An accepted push sets outbound status bit 3.
- R6: A host write to 0x44 returns its data to the free pool. The returned offset comes back from a host read of 0x40 after the entries already in the pool.
- R7: A write to a full queue (capacity DEPTH, default 8) is dropped. It sets outbound status bit 4, which stays set until it is cleared.
- R8: Outbound status is read at host 0x30, and writing 1 to a bit there clears it. The outbound mask is at host 0x34, where a 1 blocks a bit. `host_irq` is the OR of the unmasked outbound status bits.
- R9: Local writes to outbound message 0 or 1 (local 0x10 and 0x14) set outbound status bit 0 or bit 1. A write to outbound message 0 whose value equals inbound message 0 also sets bit 2. The host reads the outbound messages at 0x18 and 0x1C.
- R10: Host writes to inbound message 0 or 1 (0x10 and 0x14) set inbound status bit 0 or bit 1; the local side reads them at 0x08 and 0x0C. A host write to 0x20 ORs its data into the doorbell, and a nonzero write sets inbound status bit 2. A local write to 0x18 clears the doorbell bits written as 1. Any host post sets inbound status bit 3.
- R11: Inbound status is at local 0x1C, where writing 1 clears a bit, and the inbound mask is at local 0x20. The host reads them at 0x24 and 0x28. `loc_irq` is the OR of the unmasked inbound status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | ADDR_W | Host register byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the cycle of the access |
| host_irq | output | 1 | Host interrupt |
| loc_sel | input | 1 | Local access strobe |
| loc_wr | input | 1 | 1 = local write, 0 = local read |
| loc_addr | input | ADDR_W | Local register byte address |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data, valid in the cycle of the access |
| loc_irq | output | 1 | Local controller interrupt |

## Verification
The properties assume that each side issues at most one access per cycle and holds its strobe for exactly one cycle per access, so that every cycle with `host_sel` or `loc_sel` high counts as one pop or push. The properties also assume the free pool never holds more than DEPTH entries. The bench tasks raise a strobe for a single clock edge and drop it straight after. They never return more offsets to the free pool than it can hold. The random phase mixes host posts, local drains, local completions and host retrievals against a bench queue model, and it deliberately lets the posted queue fill and overflow.

// File: rtl/mu_pkg.sv
// Package: shared address map and status bit positions for the messaging unit.
// Assumes byte addresses on both sides. Values are compared after sizing to ADDR_W.
package mu_pkg;
    // Host-side map
    localparam int unsigned HA_IMSG0  = 'h10;
    localparam int unsigned HA_IMSG1  = 'h14;
    localparam int unsigned HA_OMSG0  = 'h18;
    localparam int unsigned HA_OMSG1  = 'h1C;
    localparam int unsigned HA_DBELL  = 'h20;
    localparam int unsigned HA_ISTAT  = 'h24;
    localparam int unsigned HA_IMASK  = 'h28;
    localparam int unsigned HA_OSTAT  = 'h30;
    localparam int unsigned HA_OMASK  = 'h34;
    localparam int unsigned HA_INQ    = 'h40;
    localparam int unsigned HA_OUTQ   = 'h44;
    // Local-side map
    localparam int unsigned LA_TAKE   = 'h00;
    localparam int unsigned LA_DONE   = 'h04;
    localparam int unsigned LA_IMSG0  = 'h08;
    localparam int unsigned LA_IMSG1  = 'h0C;
    localparam int unsigned LA_OMSG0  = 'h10;
    localparam int unsigned LA_OMSG1  = 'h14;
    localparam int unsigned LA_DBELL  = 'h18;
    localparam int unsigned LA_ISTAT  = 'h1C;
    localparam int unsigned LA_IMASK  = 'h20;
    // Outbound status bits
    localparam int unsigned OB_MSG0   = 0;
    localparam int unsigned OB_MSG1   = 1;
    localparam int unsigned OB_ECHO   = 2;
    localparam int unsigned OB_DONE   = 3;
    localparam int unsigned OB_OVF    = 4;
    localparam int unsigned OB_W      = 5;
    // Inbound status bits
    localparam int unsigned IB_MSG0   = 0;
    localparam int unsigned IB_MSG1   = 1;
    localparam int unsigned IB_DBELL  = 2;
    localparam int unsigned IB_POST   = 3;
    localparam int unsigned IB_W      = 4;
    localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;
endpackage

// File: rtl/mu_fifo.sv
// Module: token FIFO with optional preload at reset.
// Assumes DEPTH is a power of two, at least 2, and PRE_N <= DEPTH.
// Push and pop may happen in the same cycle, also when full.
// A pop of an empty FIFO is ignored. A push to a full FIFO without a pop is dropped and flagged.
module mu_fifo #(
    parameter int unsigned W        = 32,
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned PRE_N    = 0,
    parameter int unsigned PRE_BASE = 0,
    parameter int unsigned PRE_STEP = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [W-1:0]                wdata,
    input  logic                        pop,
    output logic [W-1:0]                rdata,
    output logic                        taken,
    output logic                        dropped,
    output logic [$clog2(DEPTH):0]      count
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = PW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          empty, full, do_pop;

    // Occupancy flags and accepted operations
    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CW'(DEPTH));
        do_pop  = pop && !empty;
        taken   = push && (!full || do_pop);
        dropped = push && full && !do_pop;
        rdata   = empty ? {W{1'b1}} : mem[rd_ptr];
        count   = cnt;
    end

    // One storage word per slot, preloaded with its reset offset
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [W-1:0] INIT = (i < PRE_N) ? W'(PRE_BASE + i * PRE_STEP) : '0;
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= INIT;
            else if (taken && wr_ptr == PW'(i))
                mem[i] <= wdata;
        end
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= PW'(PRE_N % DEPTH);
            cnt    <= CW'(PRE_N);
        end else begin
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            if (taken)  wr_ptr <= wr_ptr + 1'b1;
            case ({taken, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/mu_irq.sv
// Module: interrupt status and mask pair.
// Bits set by pulses stay set until a write-1-to-clear. A set in the same cycle wins.
// A mask bit of 1 blocks its status bit from the interrupt output. Mask resets to 0.
module mu_irq #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] clr;

    // Select the bits cleared this cycle
    always_comb clr = clr_en ? clr_bits : '0;

    // Sticky status with write-1-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | set;
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    // Interrupt is any unmasked status bit
    always_comb irq = |(status & ~mask);
endmodule

// File: rtl/mu_top.sv
// Module: messaging unit with queue ports, message registers, doorbell and interrupts.
// Assumes one access per side per cycle, with a strobe of one cycle per access.
// Read data is combinational in the access cycle. Pops and pushes take effect at the clock edge.
// Tokens are opaque. The block never interprets the tagged host-address form.
module mu_top #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned FREE_COUNT = 4,
    parameter int unsigned FREE_BASE  = 'h1000,
    parameter int unsigned FREE_STEP  = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_irq,
    input  logic              loc_sel,
    input  logic              loc_wr,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [31:0]       loc_wdata,
    output logic [31:0]       loc_rdata,
    output logic              loc_irq
);
    import mu_pkg::*;
    localparam int unsigned CW = $clog2(DEPTH) + 1;

    logic h_rd, h_wr, l_rd, l_wr;
    logic [31:0] imsg0_q, imsg1_q, omsg0_q, omsg1_q, dbell_q;
    logic [31:0] free_head, post_head, done_head;
    logic free_push, free_pop, post_push, post_pop, done_push, done_pop;
    logic free_taken, post_taken, done_taken;
    logic free_drop, post_drop, done_drop;
    logic [CW-1:0] free_cnt, post_cnt, done_cnt;
    logic [OB_W-1:0] ost_set, ost_q, omask_q;
    logic [IB_W-1:0] ist_set, ist_q, imask_q;
    logic echo_hit;

    // Access qualifiers and queue strobes
    always_comb begin
        h_rd      = host_sel && !host_wr;
        h_wr      = host_sel &&  host_wr;
        l_rd      = loc_sel  && !loc_wr;
        l_wr      = loc_sel  &&  loc_wr;
        free_pop  = h_rd && host_addr == ADDR_W'(HA_INQ);
        free_push = h_wr && host_addr == ADDR_W'(HA_OUTQ);
        post_push = h_wr && host_addr == ADDR_W'(HA_INQ);
        post_pop  = l_rd && loc_addr  == ADDR_W'(LA_TAKE);
        done_push = l_wr && loc_addr  == ADDR_W'(LA_DONE);
        done_pop  = h_rd && host_addr == ADDR_W'(HA_OUTQ);
    end

    // Free pool: preloaded offsets, handed out and returned by the host
    mu_fifo #(.W(32), .DEPTH(DEPTH), .PRE_N(FREE_COUNT),
              .PRE_BASE(FREE_BASE), .PRE_STEP(FREE_STEP)) u_free (
        .clk(clk), .rst_n(rst_n), .push(free_push), .wdata(host_wdata),
        .pop(free_pop), .rdata(free_head), .taken(free_taken),
        .dropped(free_drop), .count(free_cnt));

    // Posted requests: host to local
    mu_fifo #(.W(32), .DEPTH(DEPTH), .PRE_N(0),
              .PRE_BASE(0), .PRE_STEP(0)) u_post (
        .clk(clk), .rst_n(rst_n), .push(post_push), .wdata(host_wdata),
        .pop(post_pop), .rdata(post_head), .taken(post_taken),
        .dropped(post_drop), .count(post_cnt));

    // Completions: local to host
    mu_fifo #(.W(32), .DEPTH(DEPTH), .PRE_N(0),
              .PRE_BASE(0), .PRE_STEP(0)) u_done (
        .clk(clk), .rst_n(rst_n), .push(done_push), .wdata(loc_wdata),
        .pop(done_pop), .rdata(done_head), .taken(done_taken),
        .dropped(done_drop), .count(done_cnt));

    // Inbound message registers, written by the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imsg0_q <= '0;
            imsg1_q <= '0;
        end else if (h_wr) begin
            if (host_addr == ADDR_W'(HA_IMSG0)) imsg0_q <= host_wdata;
            if (host_addr == ADDR_W'(HA_IMSG1)) imsg1_q <= host_wdata;
        end
    end

    // Outbound message registers, written by the local side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            omsg0_q <= '0;
            omsg1_q <= '0;
        end else if (l_wr) begin
            if (loc_addr == ADDR_W'(LA_OMSG0)) omsg0_q <= loc_wdata;
            if (loc_addr == ADDR_W'(LA_OMSG1)) omsg1_q <= loc_wdata;
        end
    end

    // Doorbell: host ORs bits in, local clears bits written as 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbell_q <= '0;
        end else begin
            dbell_q <= (dbell_q
                        | ((h_wr && host_addr == ADDR_W'(HA_DBELL)) ? host_wdata : 32'h0))
                       & ~((l_wr && loc_addr == ADDR_W'(LA_DBELL)) ? loc_wdata : 32'h0);
        end
    end

    // Echo of inbound message 0 through outbound message 0 marks command completion
    always_comb echo_hit = l_wr && loc_addr == ADDR_W'(LA_OMSG0) && loc_wdata == imsg0_q;

    // Interrupt cause pulses for both directions
    always_comb begin
        ost_set          = '0;
        ost_set[OB_MSG0] = l_wr && loc_addr == ADDR_W'(LA_OMSG0);
        ost_set[OB_MSG1] = l_wr && loc_addr == ADDR_W'(LA_OMSG1);
        ost_set[OB_ECHO] = echo_hit;
        ost_set[OB_DONE] = done_taken;
        ost_set[OB_OVF]  = free_drop || post_drop || done_drop;
        ist_set           = '0;
        ist_set[IB_MSG0]  = h_wr && host_addr == ADDR_W'(HA_IMSG0);
        ist_set[IB_MSG1]  = h_wr && host_addr == ADDR_W'(HA_IMSG1);
        ist_set[IB_DBELL] = h_wr && host_addr == ADDR_W'(HA_DBELL) && host_wdata != 32'h0;
        ist_set[IB_POST]  = post_taken;
    end

    // Host-facing interrupt: cleared and masked by the host
    mu_irq #(.N(OB_W)) u_oirq (
        .clk(clk), .rst_n(rst_n), .set(ost_set),
        .clr_en(h_wr && host_addr == ADDR_W'(HA_OSTAT)), .clr_bits(host_wdata[OB_W-1:0]),
        .mask_we(h_wr && host_addr == ADDR_W'(HA_OMASK)), .mask_wdata(host_wdata[OB_W-1:0]),
        .status(ost_q), .mask(omask_q), .irq(host_irq));

    // Local-facing interrupt: cleared and masked by the local side
    mu_irq #(.N(IB_W)) u_iirq (
        .clk(clk), .rst_n(rst_n), .set(ist_set),
        .clr_en(l_wr && loc_addr == ADDR_W'(LA_ISTAT)), .clr_bits(loc_wdata[IB_W-1:0]),
        .mask_we(l_wr && loc_addr == ADDR_W'(LA_IMASK)), .mask_wdata(loc_wdata[IB_W-1:0]),
        .status(ist_q), .mask(imask_q), .irq(loc_irq));

    // Host read multiplexer
    always_comb begin
        case (host_addr)
            ADDR_W'(HA_IMSG0): host_rdata = imsg0_q;
            ADDR_W'(HA_IMSG1): host_rdata = imsg1_q;
            ADDR_W'(HA_OMSG0): host_rdata = omsg0_q;
            ADDR_W'(HA_OMSG1): host_rdata = omsg1_q;
            ADDR_W'(HA_DBELL): host_rdata = dbell_q;
            ADDR_W'(HA_ISTAT): host_rdata = 32'(ist_q);
            ADDR_W'(HA_IMASK): host_rdata = 32'(imask_q);
            ADDR_W'(HA_OSTAT): host_rdata = 32'(ost_q);
            ADDR_W'(HA_OMASK): host_rdata = 32'(omask_q);
            ADDR_W'(HA_INQ):   host_rdata = free_head;
            ADDR_W'(HA_OUTQ):  host_rdata = done_head;
            default:           host_rdata = 32'h0;
        endcase
    end

    // Local read multiplexer
    always_comb begin
        case (loc_addr)
            ADDR_W'(LA_TAKE):  loc_rdata = post_head;
            ADDR_W'(LA_IMSG0): loc_rdata = imsg0_q;
            ADDR_W'(LA_IMSG1): loc_rdata = imsg1_q;
            ADDR_W'(LA_OMSG0): loc_rdata = omsg0_q;
            ADDR_W'(LA_OMSG1): loc_rdata = omsg1_q;
            ADDR_W'(LA_DBELL): loc_rdata = dbell_q;
            ADDR_W'(LA_ISTAT): loc_rdata = 32'(ist_q);
            ADDR_W'(LA_IMASK): loc_rdata = 32'(imask_q);
            default:           loc_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/mu_checker.sv
// Module: protocol properties for mu_top, attached by bind below.
// Assumes single-cycle access strobes. It observes the ports and the status, mask and count state.
module mu_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DEPTH  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_sel,
    input logic                   host_wr,
    input logic [ADDR_W-1:0]      host_addr,
    input logic [31:0]            host_wdata,
    input logic [31:0]            host_rdata,
    input logic                   host_irq,
    input logic                   loc_sel,
    input logic                   loc_wr,
    input logic [ADDR_W-1:0]      loc_addr,
    input logic [31:0]            loc_wdata,
    input logic [4:0]             ost_q,
    input logic [4:0]             omask_q,
    input logic [31:0]            imsg0_q,
    input logic [$clog2(DEPTH):0] free_cnt
);
    AST_EMPTY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_wr && host_addr == ADDR_W'('h40) && free_cnt == '0)
        |-> host_rdata == 32'hFFFF_FFFF); // R3

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= ($clog2(DEPTH)+1)'(DEPTH)); // R2

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_sel && loc_wr && loc_addr == ADDR_W'('h04)) |=> (ost_q[3] || ost_q[4])); // R5

    AST_NO_LOST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ost_q[4] && !(host_sel && host_wr && host_addr == ADDR_W'('h30) && host_wdata[4]))
        |=> ost_q[4]); // R7

    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&omask_q) |-> !host_irq); // R8

    AST_ECHO_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_sel && loc_wr && loc_addr == ADDR_W'('h10) && loc_wdata == imsg0_q)
        |=> ost_q[2]); // R9
endmodule

bind mu_top mu_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .loc_sel(loc_sel), .loc_wr(loc_wr), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .ost_q(ost_q), .omask_q(omask_q), .imsg0_q(imsg0_q),
    .free_cnt(free_cnt));

// File: tb/tb_mu_top.sv
// Bench for mu_top: directed corner cases, then seeded random traffic checked against a queue model.
module tb_mu_top;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DEPTH  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sel = 1'b0, host_wr = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic host_irq;
    logic loc_sel = 1'b0, loc_wr = 1'b0;
    logic [ADDR_W-1:0] loc_addr = '0;
    logic [31:0] loc_wdata = '0;
    logic [31:0] loc_rdata;
    logic loc_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] post_m[$];
    logic [31:0] done_m[$];

    always #2.5 clk = ~clk;

    mu_top #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq(host_irq), .loc_sel(loc_sel), .loc_wr(loc_wr), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_irq(loc_irq));

    function automatic logic [31:0] tag_host(input logic [31:0] byte_addr);
        return 32'h8000_0000 | (byte_addr >> 5);
    endfunction

    function automatic logic [31:0] free_off(input int i);
        return 32'h1000 + 32'(i) * 32'h100;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_sel = 1'b0;
    endtask

    task automatic lw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        loc_sel = 1'b1; loc_wr = 1'b1; loc_addr = a; loc_wdata = d;
        @(posedge clk); #1;
        loc_sel = 1'b0; loc_wr = 1'b0;
    endtask

    task automatic lr(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        loc_sel = 1'b1; loc_wr = 1'b0; loc_addr = a;
        #1 d = loc_rdata;
        @(posedge clk); #1;
        loc_sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] tok [9];
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        hr(8'h30, d); chk("R1", "ostat", d, 32'h0);
        hr(8'h34, d); chk("R1", "omask", d, 32'h0);
        hr(8'h10, d); chk("R1", "imsg0", d, 32'h0);
        hr(8'h24, d); chk("R1", "istat", d, 32'h0);
        hr(8'h20, d); chk("R1", "dbell", d, 32'h0);
        chk("R1", "host_irq", 32'(host_irq), 32'h0);
        chk("R1", "loc_irq", 32'(loc_irq), 32'h0);
        lr(8'h00, d); chk("R3", "local empty take", d, 32'hFFFF_FFFF);
        hr(8'h44, d); chk("R3", "host empty done", d, 32'hFFFF_FFFF);

        // R2 preloaded free pool, R3 empty pool
        for (int i = 0; i < 4; i++) begin
            hr(8'h40, d); chk("R2", "free offset", d, free_off(i));
        end
        hr(8'h40, d); chk("R3", "empty free", d, 32'hFFFF_FFFF);
        hr(8'h30, d); chk("R3", "empty read leaves status", d, 32'h0);

        // R6 returned offsets come back in order
        hw(8'h44, 32'h1200);
        hw(8'h44, 32'h1000);
        hr(8'h40, d); chk("R6", "returned first", d, 32'h1200);
        hr(8'h40, d); chk("R6", "returned second", d, 32'h1000);
        hr(8'h40, d); chk("R3", "pool drained", d, 32'hFFFF_FFFF);

        // R4 posting with device offsets and tagged host addresses
        tok[0] = 32'h0000_1100;
        tok[1] = tag_host(32'h1234_5660);
        tok[2] = tag_host(32'hFFFF_FFE0);
        for (int i = 0; i < 3; i++) hw(8'h40, tok[i]);
        hr(8'h24, d); chk("R10", "post sets istat bit3", d, 32'h8);
        chk("R11", "loc_irq on post", 32'(loc_irq), 32'h1);
        for (int i = 0; i < 3; i++) begin
            lr(8'h00, d); chk("R4", "posted token", d, tok[i]);
        end
        lr(8'h00, d); chk("R3", "posted drained", d, 32'hFFFF_FFFF);
        lw(8'h1C, 32'hF);
        lr(8'h1C, d); chk("R11", "istat cleared", d, 32'h0);
        chk("R11", "loc_irq cleared", 32'(loc_irq), 32'h0);

        // R7 overflow of the posted queue
        for (int i = 0; i < 9; i++) begin
            tok[i] = 32'hA000_0000 + 32'(i);
            hw(8'h40, tok[i]);
        end
        hr(8'h30, d); chk("R7", "overflow flag", d, 32'h10);
        chk("R8", "host_irq on overflow", 32'(host_irq), 32'h1);
        for (int i = 0; i < 8; i++) begin
            lr(8'h00, d); chk("R7", "kept token", d, tok[i]);
        end
        lr(8'h00, d); chk("R7", "ninth dropped", d, 32'hFFFF_FFFF);
        hr(8'h30, d); chk("R7", "overflow sticky", d, 32'h10);
        hw(8'h30, 32'h10);
        hr(8'h30, d); chk("R8", "w1c overflow", d, 32'h0);
        lw(8'h1C, 32'hF);

        // R5 completion path
        lw(8'h04, 32'h0000_0ABC);
        hr(8'h30, d); chk("R5", "done flag", d, 32'h8);
        chk("R8", "host_irq on done", 32'(host_irq), 32'h1);
        hr(8'h44, d); chk("R5", "completion token", d, 32'h0000_0ABC);
        hr(8'h44, d); chk("R3", "done drained", d, 32'hFFFF_FFFF);

        // R8 clear and mask
        hw(8'h30, 32'h8);
        chk("R8", "irq after clear", 32'(host_irq), 32'h0);
        hw(8'h34, 32'h8);
        lw(8'h04, 32'h55);
        hr(8'h30, d); chk("R8", "masked bit still set", d, 32'h8);
        chk("R8", "masked irq low", 32'(host_irq), 32'h0);
        hr(8'h34, d); chk("R8", "omask readback", d, 32'h8);
        hw(8'h34, 32'h0);
        chk("R8", "unmask raises irq", 32'(host_irq), 32'h1);
        hr(8'h44, d); chk("R5", "second completion", d, 32'h55);
        hw(8'h30, 32'h1F);
        chk("R8", "all cleared", 32'(host_irq), 32'h0);

        // R9 message echo
        hw(8'h10, 32'hC0DE_0001);
        lr(8'h08, d); chk("R10", "imsg0 at local", d, 32'hC0DE_0001);
        lr(8'h1C, d); chk("R10", "istat msg0", d, 32'h1);
        lw(8'h10, 32'hC0DE_0002);
        hr(8'h30, d); chk("R9", "mismatch no echo", d, 32'h1);
        lw(8'h10, 32'hC0DE_0001);
        hr(8'h30, d); chk("R9", "echo flagged", d, 32'h5);
        hr(8'h18, d); chk("R9", "omsg0 readback", d, 32'hC0DE_0001);
        lw(8'h14, 32'h7777);
        hr(8'h30, d); chk("R9", "omsg1 flag", d, 32'h7);
        hr(8'h1C, d); chk("R9", "omsg1 readback", d, 32'h7777);
        hw(8'h30, 32'h1F);
        lw(8'h1C, 32'hF);

        // R10 doorbell
        hw(8'h20, 32'h3);
        hw(8'h20, 32'h4);
        lr(8'h18, d); chk("R10", "doorbell OR", d, 32'h7);
        lr(8'h1C, d); chk("R10", "istat doorbell", d, 32'h4);
        lw(8'h18, 32'h1);
        hr(8'h20, d); chk("R10", "doorbell w1c", d, 32'h6);
        lw(8'h1C, 32'hF);
        hw(8'h20, 32'h0);
        lr(8'h1C, d); chk("R10", "zero doorbell no flag", d, 32'h0);

        // R11 inbound mask
        lw(8'h20, 32'hF);
        hw(8'h14, 32'h1111);
        hr(8'h24, d); chk("R11", "istat msg1", d, 32'h2);
        chk("R11", "masked loc_irq", 32'(loc_irq), 32'h0);
        hr(8'h28, d); chk("R11", "imask at host", d, 32'hF);
        lr(8'h0C, d); chk("R10", "imsg1 at local", d, 32'h1111);
        lw(8'h20, 32'h0);
        chk("R11", "unmasked loc_irq", 32'(loc_irq), 32'h1);
        lw(8'h1C, 32'hF);

        // R4 R5 R7 random traffic against the queue model
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [31:0] v;
            op = int'($urandom % 4);
            v  = $urandom;
            case (op)
                0: begin
                    if (v[0]) v = tag_host(v & 32'hFFFF_FFE0);
                    hw(8'h40, v);
                    if (post_m.size() < DEPTH) post_m.push_back(v);
                end
                1: begin
                    lr(8'h00, d);
                    if (post_m.size() == 0) chk("R3", "rand empty take", d, 32'hFFFF_FFFF);
                    else chk("R4", "rand take", d, post_m.pop_front());
                end
                2: begin
                    lw(8'h04, v);
                    if (done_m.size() < DEPTH) done_m.push_back(v);
                end
                default: begin
                    hr(8'h44, d);
                    if (done_m.size() == 0) chk("R3", "rand empty done", d, 32'hFFFF_FFFF);
                    else chk("R5", "rand done", d, done_m.pop_front());
                end
            endcase
        end
        finish_run();
    end
endmodule